// File: doc/BRIEF.md
# MDIO Management Master with Control Registers

This block is a memory-mapped management-bus master for external Ethernet PHYs. It can send both the Clause 22 and the Clause 45 frame formats. Software sees five 64-bit registers through a simple write strobe and a combinational read port. A configuration register selects the frame format, turns the 32-bit preamble on or off, and sets the MDC half-period in system clocks. An enable register gates all bus activity.

Writing the command register starts one serial frame on MDC/MDIO. Software then polls a pending bit. That bit sits in the write-data register for write and address frames, and in the read-data register for reads. When a read finishes, the read-data register holds the 16 returned bits and a valid flag. The opcode field of the command register means different frame types depending on the format bit. The frame contents are latched when the frame starts, so later register writes cannot disturb a frame that is running.

Top module: `mdio_csr_ctrl`

## Requirements
- R1: After reset, MDC is low, MDIO is not driven (`mdio_oe`=0), and every register reads back as zero.
- R2: While enable bit 0 of the register at 0x20 is clear, a command write starts no frame: MDC stays low, MDIO stays undriven and no pending bit sets.
- R3: A Clause 22 write (format bit 0, opcode 0) with the preamble on sends, MSB first, 32 ones, then start 01, op 01, the PHY address, the register address, turnaround 10 and the 16 data bits from bits [15:0] of the write-data register (0x08). MDIO is driven for all 64 bits.
- R4: A frame of n bits with half-period h occupies 2·h·n cycles after the command write. The pending bit (bit 17) is set for that time and clear one cycle later. It is in the write-data register for write and address frames and in the read-data register (0x10) for reads, and the other register's pending bit stays clear.
- R5: A Clause 22 read (opcode 1) sends start 01 and op 10. MDIO is driven for the first 14 frame bits (excluding preamble) and released for the remaining 18. The 16 bits sampled after the turnaround appear in bits [15:0] of 0x10, with valid bit 16 set.
- R6: Valid bit 16 clears when a read starts. It ends low if the PHY does not hold MDIO low in the second turnaround bit.
- R7: In Clause 45 mode (format bit 24 of 0x18 set), opcode 0 sends an address frame: start 00, op 00, PHY address, device address from the register-address field, turnaround 10, and the 16-bit register number from the write-data register.
- R8: In Clause 45 mode, opcode 1 is a write (op 01), opcode 3 is a read (op 11), and opcode 2 is a read with post-increment (op 10). Both read kinds return data and valid as in R5.
- R9: With preamble bit 12 of 0x18 clear, a frame is exactly 32 MDC periods long and starts directly with the start bits.
- R10: MDC has a half-period of `div` system clocks, where `div` is bits [7:0] of 0x18, and a value of 0 behaves as 1. MDIO output changes only when MDC falls, and MDC is low whenever no frame runs.
- R11: A command write while a frame is pending is ignored: the running frame completes unchanged and no second frame follows.
- R12: In Clause 22 mode, opcodes 2 and 3 start no frame.
- R13: Register fields read back at fixed positions. The command register at 0x00 holds the opcode in [17:16], the PHY address in [12:8] and the register/device address in [4:0]. The configuration register at 0x18 holds the divider in [7:0], the preamble bit at 12 and the format bit at 24. The enable bit is bit 0 of 0x20. Unused bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 6 | Register byte offset |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Register read data for `csr_addr` (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (high: block drives the line) |
| mdio_i | input | 1 | MDIO input value from the pad |

## Verification
The write strobe is taken at edge E0. Pending reads back set from the next cycle through edge E0+2·h·n−1, and clear after edge E0+2·h·n. The bench counts falling clock edges from the end of its write task so that it samples exactly at those two points, both for a preamble frame with h=2 and for a divider value of 0. MDC rises h cycles after the start and every 2·h cycles after that, so the bench records the clock count at each MDC rise and compares the spacing. Frame bits, the output enable and the PHY's replies are sampled at MDC rises and driven at MDC falls, and the read-data register is checked only after both pending bits are clear.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int CSR_W       = 64;
  localparam int CSR_ADDR_W  = 6;
  localparam int MD_DATA_W   = 16;
  localparam int MD_ADDR_W   = 5;
  localparam int PRE_BITS    = 32;
  localparam int BODY_BITS   = 32;
  localparam int FRAME_BITS  = PRE_BITS + BODY_BITS;
  localparam int IDX_W       = $clog2(FRAME_BITS);
  localparam int HDR_BITS    = 14;   // start, op, phy, reg
  localparam int TA_BITS     = 2;

  localparam logic [CSR_ADDR_W-1:0] OFS_CMD  = 6'h00;
  localparam logic [CSR_ADDR_W-1:0] OFS_WDAT = 6'h08;
  localparam logic [CSR_ADDR_W-1:0] OFS_RDAT = 6'h10;
  localparam logic [CSR_ADDR_W-1:0] OFS_CFG  = 6'h18;
  localparam logic [CSR_ADDR_W-1:0] OFS_EN   = 6'h20;

  localparam int CMD_REG_LSB = 0;
  localparam int CMD_PHY_LSB = 8;
  localparam int CMD_OP_LSB  = 16;
  localparam int PEND_BIT    = 17;
  localparam int VALID_BIT   = 16;
  localparam int CFG_PRE_BIT = 12;
  localparam int CFG_C45_BIT = 24;

  typedef struct packed {
    logic [1:0]           op;
    logic [MD_ADDR_W-1:0] phy;
    logic [MD_ADDR_W-1:0] regad;
  } md_cmd_t;

  // Clause 22 only knows two opcodes; Clause 45 uses all four.
  function automatic logic op_accepted(input logic c45, input logic [1:0] op);
    return c45 || !op[1];
  endfunction

  function automatic logic op_reads(input logic c45, input logic [1:0] op);
    return c45 ? op[1] : op[0];
  endfunction

  // start bits followed by the two opcode bits on the wire
  function automatic logic [3:0] frame_head(input logic c45, input logic [1:0] op);
    if (c45) return {2'b00, op};
    return {2'b01, (op[0] ? 2'b10 : 2'b01)};
  endfunction

  function automatic logic [BODY_BITS-1:0] frame_body(input logic c45, input md_cmd_t cmd,
                                                      input logic [MD_DATA_W-1:0] data);
    logic rd;
    rd = op_reads(c45, cmd.op);
    return {frame_head(c45, cmd.op), cmd.phy, cmd.regad,
            (rd ? 2'b11 : 2'b10), (rd ? {MD_DATA_W{1'b1}} : data)};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] hc;
  logic [DIV_W-1:0] lim_m1;
  logic             wrap;

  always_comb lim_m1 = (half_div == '0) ? '0 : half_div - 1'b1;

  assign wrap = run && (hc == lim_m1);
  assign rise = wrap && !mdc;
  assign fall = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc  <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      hc  <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      hc  <= '0;
      mdc <= !mdc;
    end else begin
      hc  <= hc + 1'b1;
    end
  end

  // R10: no clock activity between frames
  p_mdc_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc) else $error("mdc active while idle");
endmodule

// File: rtl/mdio_seq.sv
`timescale 1ns/1ps
module mdio_seq
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 c45,
  input  logic                 pre_en,
  input  md_cmd_t              cmd,
  input  logic [MD_DATA_W-1:0] wdata,
  input  logic                 rise,
  input  logic                 fall,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 is_rd,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 rd_valid,
  output logic [MD_DATA_W-1:0] rd_data,
  output logic                 done
);
  localparam logic [IDX_W-1:0] IDX_FIRST_BODY = IDX_W'(PRE_BITS);
  localparam logic [IDX_W-1:0] IDX_TA1  = IDX_W'(PRE_BITS + HDR_BITS);
  localparam logic [IDX_W-1:0] IDX_TA2  = IDX_W'(PRE_BITS + HDR_BITS + 1);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(PRE_BITS + HDR_BITS + TA_BITS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] frame;
  logic [IDX_W-1:0]      idx;
  logic                  ta_ok;
  logic [MD_DATA_W-1:0]  rx_sh;
  logic                  last_bit;
  logic                  rd_req;
  logic [BODY_BITS-1:0]  body;

  assign last_bit = (idx == IDX_LAST);
  assign done     = busy && fall && last_bit;
  assign rd_req   = op_reads(c45, cmd.op);
  assign body     = frame_body(c45, cmd, wdata);
  assign mdio_o   = busy ? frame[FRAME_BITS-1] : 1'b1;
  assign mdio_oe  = busy && !(is_rd && (idx >= IDX_TA1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      is_rd    <= 1'b0;
      idx      <= '0;
      frame    <= '1;
      ta_ok    <= 1'b0;
      rx_sh    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      is_rd <= rd_req;
      ta_ok <= 1'b0;
      frame <= pre_en ? {{PRE_BITS{1'b1}}, body} : {body, {PRE_BITS{1'b1}}};
      idx   <= pre_en ? '0 : IDX_FIRST_BODY;
      if (rd_req) rd_valid <= 1'b0;
    end else if (busy) begin
      if (rise && is_rd) begin
        if (idx == IDX_TA2) ta_ok <= !mdio_i;
        if (idx >= IDX_DATA) rx_sh <= {rx_sh[MD_DATA_W-2:0], mdio_i};
      end
      if (fall) begin
        if (last_bit) begin
          busy <= 1'b0;
          if (is_rd) begin
            rd_valid <= ta_ok;
            rd_data  <= rx_sh;
          end
        end else begin
          idx   <= idx + 1'b1;
          frame <= {frame[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  // R4: a frame only ends on a falling MDC edge
  p_busy_ends_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(fall)) else $error("frame ended off an mdc fall");

  // R11: a running frame's bits change only by shifting on MDC falls
  p_frame_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fall |=> $stable(frame)) else $error("frame bits disturbed");
endmodule

// File: rtl/mdio_regs.sv
`timescale 1ns/1ps
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  csr_wr,
  input  logic [CSR_ADDR_W-1:0] csr_addr,
  input  logic [CSR_W-1:0]      csr_wdata,
  output logic [CSR_W-1:0]      csr_rdata,
  input  logic                  busy,
  input  logic                  is_rd,
  input  logic                  rd_valid,
  input  logic [MD_DATA_W-1:0]  rd_data,
  output md_cmd_t               cmd_in,
  output logic [MD_DATA_W-1:0]  wdat_q,
  output logic                  c45_q,
  output logic                  pre_q,
  output logic [DIV_W-1:0]      div_q,
  output logic                  en_q,
  output logic                  start
);
  md_cmd_t cmd_q;
  logic    wr_cmd;
  logic    unused_wbits;

  assign unused_wbits = ^{csr_wdata[CSR_W-1:CFG_C45_BIT+1], csr_wdata[CFG_C45_BIT-1:PEND_BIT+1]};

  assign cmd_in = {csr_wdata[CMD_OP_LSB +: 2], csr_wdata[CMD_PHY_LSB +: MD_ADDR_W],
                   csr_wdata[CMD_REG_LSB +: MD_ADDR_W]};
  assign wr_cmd = csr_wr && (csr_addr == OFS_CMD) && !busy;
  assign start  = wr_cmd && en_q && op_accepted(c45_q, cmd_in.op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      wdat_q <= '0;
      c45_q  <= 1'b0;
      pre_q  <= 1'b0;
      div_q  <= '0;
      en_q   <= 1'b0;
    end else if (csr_wr) begin
      if (wr_cmd) cmd_q <= cmd_in;
      if (csr_addr == OFS_WDAT) wdat_q <= csr_wdata[MD_DATA_W-1:0];
      if (csr_addr == OFS_CFG) begin
        div_q <= csr_wdata[DIV_W-1:0];
        pre_q <= csr_wdata[CFG_PRE_BIT];
        c45_q <= csr_wdata[CFG_C45_BIT];
      end
      if (csr_addr == OFS_EN) en_q <= csr_wdata[0];
    end
  end

  always_comb begin
    csr_rdata = '0;
    unique case (csr_addr)
      OFS_CMD: begin
        csr_rdata[CMD_OP_LSB +: 2]          = cmd_q.op;
        csr_rdata[CMD_PHY_LSB +: MD_ADDR_W] = cmd_q.phy;
        csr_rdata[CMD_REG_LSB +: MD_ADDR_W] = cmd_q.regad;
      end
      OFS_WDAT: begin
        csr_rdata[MD_DATA_W-1:0] = wdat_q;
        csr_rdata[PEND_BIT]      = busy && !is_rd;
      end
      OFS_RDAT: begin
        csr_rdata[MD_DATA_W-1:0] = rd_data;
        csr_rdata[VALID_BIT]     = rd_valid;
        csr_rdata[PEND_BIT]      = busy && is_rd;
      end
      OFS_CFG: begin
        csr_rdata[DIV_W-1:0]   = div_q;
        csr_rdata[CFG_PRE_BIT] = pre_q;
        csr_rdata[CFG_C45_BIT] = c45_q;
      end
      OFS_EN:  csr_rdata[0] = en_q;
      default: csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_csr_ctrl.sv
`timescale 1ns/1ps
module mdio_csr_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  csr_wr,
  input  logic [CSR_ADDR_W-1:0] csr_addr,
  input  logic [CSR_W-1:0]      csr_wdata,
  output logic [CSR_W-1:0]      csr_rdata,
  output logic                  mdc,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  input  logic                  mdio_i
);
  md_cmd_t              cmd_in;
  logic [MD_DATA_W-1:0] wdat_q;
  logic                 c45_q;
  logic                 pre_q;
  logic [DIV_W-1:0]     div_q;
  logic                 en_q;
  logic                 start;
  logic                 busy;
  logic                 is_rd;
  logic                 rd_valid;
  logic [MD_DATA_W-1:0] rd_data;
  logic                 done;
  logic                 mdc_rise;
  logic                 mdc_fall;

  mdio_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .busy(busy), .is_rd(is_rd),
    .rd_valid(rd_valid), .rd_data(rd_data), .cmd_in(cmd_in), .wdat_q(wdat_q),
    .c45_q(c45_q), .pre_q(pre_q), .div_q(div_q), .en_q(en_q), .start(start)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .half_div(div_q),
    .mdc(mdc), .rise(mdc_rise), .fall(mdc_fall)
  );

  mdio_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .c45(c45_q), .pre_en(pre_q),
    .cmd(cmd_in), .wdata(wdat_q), .rise(mdc_rise), .fall(mdc_fall),
    .mdio_i(mdio_i), .busy(busy), .is_rd(is_rd), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .rd_valid(rd_valid), .rd_data(rd_data), .done(done)
  );

  // R2: nothing starts while disabled
  p_idle_while_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && !busy |=> !busy) else $error("frame started while disabled");

  // R10: MDIO is steady while MDC is high
  p_mdio_steady_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> $stable(mdio_o)) else $error("mdio changed while mdc high");

  // R12: reserved Clause 22 opcodes start nothing
  p_c22_bad_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && csr_wr && (csr_addr == OFS_CMD) && !c45_q && csr_wdata[CMD_OP_LSB+1]
    |=> !busy) else $error("reserved clause 22 opcode started a frame");

  // R4: the end of a frame is reported exactly once and then clears
  p_done_then_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy) else $error("still pending after last bit");
endmodule

// File: tb/mdio_csr_ctrl_tb_top.sv
`timescale 1ns/1ps
module mdio_csr_ctrl_tb_top;
  localparam logic [5:0] A_CMD = 6'h00, A_WDAT = 6'h08, A_RDAT = 6'h10, A_CFG = 6'h18, A_EN = 6'h20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_wr;
  logic [5:0]  csr_addr;
  logic [63:0] csr_wdata;
  wire  [63:0] csr_rdata;
  wire         mdc, mdio_o, mdio_oe;
  logic        mdio_i;

  int n_pass = 0, n_tot = 0;
  int cyc = 0;
  int cap_n, rise_t0, rise_t1, phy_k, pre_len;
  logic [63:0] cap_d, cap_oe;
  logic [31:0] resp;

  always #2.5 clk = ~clk;   // 200 MHz

  mdio_csr_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(negedge clk) cyc++;

  always @(posedge mdc) begin
    if (cap_n == 0) rise_t0 = cyc;
    if (cap_n == 1) rise_t1 = cyc;
    cap_d  = {cap_d[62:0], mdio_o};
    cap_oe = {cap_oe[62:0], mdio_oe};
    cap_n++;
  end

  // PHY model: presents bit k of its reply from the k-th MDC fall on
  always @(negedge mdc) phy_k++;
  always @* begin
    if (phy_k >= pre_len && phy_k < pre_len + 32) mdio_i = resp[31 - (phy_k - pre_len)];
    else mdio_i = 1'b1;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_pass, n_tot);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tot++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tot++;
    if (act === exp) n_pass++;
    else $display("FAIL %s: actual %h expected %h", req, act, exp);
  endtask

  task automatic wr_csr(input logic [5:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic rd_csr(input logic [5:0] a, output logic [63:0] v);
    @(negedge clk);
    csr_addr = a;
    #1 v = csr_rdata;
  endtask

  task automatic arm(input int prelen, input logic [31:0] r);
    cap_n = 0; cap_d = '0; cap_oe = '0; phy_k = 0; pre_len = prelen; resp = r;
  endtask

  function automatic logic [63:0] cfgv(input bit c45, input bit pre, input logic [7:0] div);
    return (64'(c45) << 24) | (64'(pre) << 12) | 64'(div);
  endfunction

  function automatic logic [63:0] cmdv(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra);
    return (64'(op) << 16) | (64'(phy) << 8) | 64'(ra);
  endfunction

  function automatic logic [13:0] ehead(input bit c45, input logic [1:0] op,
                                        input logic [4:0] phy, input logic [4:0] ra);
    logic [3:0] h;
    if (c45) h = {2'b00, op};
    else if (op == 2'd0) h = 4'b0101;
    else h = 4'b0110;
    return {h, phy, ra};
  endfunction

  task automatic wait_idle();
    logic [63:0] a, b;
    for (int i = 0; i < 4000; i++) begin
      rd_csr(A_WDAT, a);
      rd_csr(A_RDAT, b);
      if (!a[17] && !b[17]) return;
    end
  endtask

  task automatic t_reset();
    logic [63:0] v;
    chk("R1 mdc", 64'(mdc), 64'd0);
    chk("R1 oe", 64'(mdio_oe), 64'd0);
    rd_csr(A_WDAT, v); chk("R1 wdat", v, 64'd0);
    rd_csr(A_RDAT, v); chk("R1 rdat", v, 64'd0);
    rd_csr(A_CFG, v);  chk("R1 cfg", v, 64'd0);
    rd_csr(A_EN, v);   chk("R1 en", v, 64'd0);
  endtask

  task automatic t_disabled_and_layout();
    logic [63:0] v;
    wr_csr(A_CFG, cfgv(0, 1, 1));
    wr_csr(A_WDAT, 64'h1234);
    arm(32, '1);
    wr_csr(A_CMD, cmdv(2'd1, 5'h15, 5'h0B));
    repeat (100) @(negedge clk);
    chk("R2 no mdc edges", 64'(cap_n), 64'd0);
    chk("R2 oe", 64'(mdio_oe), 64'd0);
    rd_csr(A_RDAT, v); chk("R2 no pending", 64'(v[17]), 64'd0);
    rd_csr(A_CMD, v);  chk("R13 cmd fields", v, 64'h0001_150B);
    wr_csr(A_CFG, '1);
    rd_csr(A_CFG, v);  chk("R13 cfg fields", v, cfgv(1, 1, 8'hFF));
    wr_csr(A_EN, 64'hFFFF);
    rd_csr(A_EN, v);   chk("R13 en field", v, 64'd1);
  endtask

  task automatic t_c22_write();
    logic [63:0] v;
    wr_csr(A_CFG, cfgv(0, 1, 2));
    wr_csr(A_WDAT, 64'hA5C3);
    arm(32, '1);
    wr_csr(A_CMD, cmdv(2'd0, 5'h11, 5'h0A));
    repeat (254) @(negedge clk);
    rd_csr(A_WDAT, v); chk("R4 wr pending last cycle", 64'(v[17]), 64'd1);
    rd_csr(A_WDAT, v); chk("R4 wr pending cleared", 64'(v[17]), 64'd0);
    chk("R3 bit count", 64'(cap_n), 64'd64);
    chk("R3 frame bits", cap_d, {32'hFFFF_FFFF, ehead(0, 2'd0, 5'h11, 5'h0A), 2'b10, 16'hA5C3});
    chk("R3 driven throughout", cap_oe, '1);
    chk("R10 half period 2", 64'(rise_t1 - rise_t0), 64'd4);
  endtask

  task automatic t_c22_read();
    logic [63:0] v;
    wr_csr(A_CFG, cfgv(0, 0, 1));
    arm(0, {14'h3FFF, 2'b10, 16'h5A0F});
    wr_csr(A_CMD, cmdv(2'd1, 5'h03, 5'h07));
    repeat (20) @(negedge clk);
    rd_csr(A_RDAT, v); chk("R4 rd pending", 64'(v[17]), 64'd1);
    rd_csr(A_WDAT, v); chk("R4 wr pending clear on read", 64'(v[17]), 64'd0);
    wait_idle();
    chk("R9 no preamble length", 64'(cap_n), 64'd32);
    chk("R5 header", 64'(cap_d[31:18]), 64'(ehead(0, 2'd1, 5'h03, 5'h07)));
    chk("R5 release", 64'(cap_oe[31:0]), 64'({14'h3FFF, 18'h0}));
    rd_csr(A_RDAT, v); chk("R5 data and valid", v, 64'h1_5A0F);
  endtask

  task automatic t_ta_bad();
    logic [63:0] v;
    arm(0, {14'h3FFF, 2'b11, 16'h1234});
    wr_csr(A_CMD, cmdv(2'd1, 5'h03, 5'h07));
    repeat (10) @(negedge clk);
    rd_csr(A_RDAT, v); chk("R6 valid cleared at start", 64'(v[16]), 64'd0);
    wait_idle();
    rd_csr(A_RDAT, v); chk("R6 valid low on bad turnaround", 64'(v[16]), 64'd0);
  endtask

  task automatic t_c45();
    logic [63:0] v;
    wr_csr(A_CFG, cfgv(1, 1, 1));
    wr_csr(A_WDAT, 64'hBEEF);
    arm(32, '1);
    wr_csr(A_CMD, cmdv(2'd0, 5'h02, 5'h1E));
    wait_idle();
    chk("R7 address frame", cap_d, {32'hFFFF_FFFF, ehead(1, 2'd0, 5'h02, 5'h1E), 2'b10, 16'hBEEF});
    wr_csr(A_CFG, cfgv(1, 0, 1));
    wr_csr(A_WDAT, 64'h0F0F);
    arm(0, '1);
    wr_csr(A_CMD, cmdv(2'd1, 5'h04, 5'h01));
    wait_idle();
    chk("R8 c45 write", 64'(cap_d[31:0]), 64'({ehead(1, 2'd1, 5'h04, 5'h01), 2'b10, 16'h0F0F}));
    arm(0, {14'h3FFF, 2'b10, 16'hC0DE});
    wr_csr(A_CMD, cmdv(2'd3, 5'h04, 5'h01));
    wait_idle();
    chk("R8 c45 read header", 64'(cap_d[31:18]), 64'(ehead(1, 2'd3, 5'h04, 5'h01)));
    rd_csr(A_RDAT, v); chk("R8 c45 read data", v, 64'h1_C0DE);
    arm(0, {14'h3FFF, 2'b10, 16'h7777});
    wr_csr(A_CMD, cmdv(2'd2, 5'h04, 5'h01));
    wait_idle();
    chk("R8 c45 incr header", 64'(cap_d[31:18]), 64'(ehead(1, 2'd2, 5'h04, 5'h01)));
    rd_csr(A_RDAT, v); chk("R8 c45 incr data", v, 64'h1_7777);
  endtask

  task automatic t_div();
    logic [63:0] v;
    wr_csr(A_CFG, cfgv(0, 0, 3));
    arm(0, '1);
    wr_csr(A_CMD, cmdv(2'd0, 5'h01, 5'h01));
    wait_idle();
    chk("R10 half period 3", 64'(rise_t1 - rise_t0), 64'd6);
    wr_csr(A_CFG, cfgv(0, 0, 0));
    arm(0, '1);
    wr_csr(A_CMD, cmdv(2'd0, 5'h01, 5'h01));
    repeat (62) @(negedge clk);
    rd_csr(A_WDAT, v); chk("R10 div0 pending last", 64'(v[17]), 64'd1);
    rd_csr(A_WDAT, v); chk("R10 div0 pending cleared", 64'(v[17]), 64'd0);
    chk("R10 div0 half period", 64'(rise_t1 - rise_t0), 64'd2);
  endtask

  task automatic t_busy_ignore();
    wr_csr(A_CFG, cfgv(0, 0, 1));
    wr_csr(A_WDAT, 64'h1111);
    arm(0, '1);
    wr_csr(A_CMD, cmdv(2'd0, 5'h01, 5'h02));
    repeat (10) @(negedge clk);
    wr_csr(A_CMD, cmdv(2'd0, 5'h09, 5'h09));
    wait_idle();
    chk("R11 first frame intact", 64'(cap_d[31:0]), 64'({ehead(0, 2'd0, 5'h01, 5'h02), 2'b10, 16'h1111}));
    repeat (100) @(negedge clk);
    chk("R11 no second frame", 64'(cap_n), 64'd32);
  endtask

  task automatic t_c22_badop();
    logic [63:0] v;
    arm(0, '1);
    wr_csr(A_CMD, cmdv(2'd2, 5'h01, 5'h01));
    repeat (5) @(negedge clk);
    wr_csr(A_CMD, cmdv(2'd3, 5'h01, 5'h01));
    repeat (80) @(negedge clk);
    chk("R12 no frame", 64'(cap_n), 64'd0);
    rd_csr(A_RDAT, v); chk("R12 no read pending", 64'(v[17]), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; csr_wr = 1'b0; csr_addr = '0; csr_wdata = '0;
    arm(0, '1);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled_and_layout();
    t_c22_write();
    t_c22_read();
    t_ta_bad();
    t_c45();
    t_div();
    t_busy_ignore();
    t_c22_badop();
    summary();
    $finish;
  end
endmodule